// File: doc/BRIEF.md
# Floating-Point Minimum/Maximum Unit

This unit takes two IEEE binary floating-point operands and returns either the smaller or the larger of them. An op input chooses between minimum and maximum. A two-bit mode input chooses how NaN operands are treated. In number-preferring mode a quiet NaN is skipped, but a signaling NaN poisons the result. In propagating mode any NaN poisons the result. In suppressing mode any single NaN, of either kind, is skipped.

The result and an invalid-operation flag are registered, so they appear one clock after the operands are presented. Signed zeros are ordered so that -0 ranks below +0. Every NaN result is the one canonical quiet NaN. The answer does not depend on which operand port a value arrives on. The exponent and fraction widths are parameters, and the defaults give binary32.

Top module: `fp_minmax_unit`

## Requirements
- R1: While rst_n is low, result and invalid are 0. Otherwise both outputs show the function of the operands, op and mode that were present at the previous rising clock edge.
- R2: For ordered, unequal operands, op_max=1 returns the larger value and op_max=0 returns the smaller. The ordering is by sign and then by magnitude, the magnitude order is reversed between two negative values, and infinities order like any other value.
- R3: When the operands compare equal (identical non-NaN encodings, or two zeros of any sign), max returns the bitwise AND of the two encodings and min returns their bitwise OR. So max(+0,-0)=+0 and min(+0,-0)=-0.
- R4: In number-preferring mode (mode 2'b00, and also 2'b11), when exactly one operand is a quiet NaN and the other is not a NaN, the non-NaN operand is returned.
- R5: In number-preferring mode, a signaling NaN on either operand gives the canonical quiet NaN, whatever the other operand is.
- R6: In propagating mode (mode 2'b01), any NaN operand, quiet or signaling, gives the canonical quiet NaN.
- R7: In suppressing mode (mode 2'b10), when exactly one operand is a NaN of either kind, the other operand is returned.
- R8: When both operands are NaN, the result is the canonical quiet NaN in every mode.
- R9: invalid is 1 exactly when at least one operand is a signaling NaN, in every mode and for both ops.
- R10: Swapping a and b never changes result or invalid, in any mode and for either op.
- R11: A NaN has an all-ones exponent and a nonzero fraction. It is signaling when its fraction MSB is 0 and quiet when that bit is 1. The canonical quiet NaN has sign 0, an all-ones exponent, and only the fraction MSB set (32'h7FC00000 for binary32).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_max | input | 1 | 1 selects maximum, 0 selects minimum |
| nan_mode | input | 2 | 00/11 number-preferring, 01 propagating, 10 suppressing |
| a | input | EXP_W+FRAC_W+1 | First operand |
| b | input | EXP_W+FRAC_W+1 | Second operand |
| result | output | EXP_W+FRAC_W+1 | Registered minimum or maximum |
| invalid | output | 1 | Registered invalid-operation flag |

## Verification
The main instance is built with EXP_W=3 and FRAC_W=2, which gives 6-bit words. At that size every pair of encodings can be applied in both port orders, for both ops and all four mode codes. The sweep therefore reaches every zero, subnormal, infinity, quiet NaN and signaling NaN, each against every other, and commutativity is checked on every pair. The expected order comes from integer magnitudes computed in the bench. A second instance at the default binary32 widths receives a few directed operands, which confirm the canonical NaN value and the signed-zero rule at full width.

// File: rtl/fp_minmax_unit.sv
module fp_minmax_unit #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      op_max,
  input  logic [1:0]                nan_mode,
  input  logic [EXP_W+FRAC_W:0]     a,
  input  logic [EXP_W+FRAC_W:0]     b,
  output logic [EXP_W+FRAC_W:0]     result,
  output logic                      invalid
);
  localparam int W = EXP_W + FRAC_W + 1;
  localparam logic [W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic a_nan, b_nan, a_snan, b_snan, both_zero, equal, a_less;
  logic [W-2:0] a_mag, b_mag;
  logic [W-1:0] ordered, nxt;

  assign a_mag  = a[W-2:0];
  assign b_mag  = b[W-2:0];
  assign a_nan  = (&a[W-2:FRAC_W]) && (a[FRAC_W-1:0] != '0);
  assign b_nan  = (&b[W-2:FRAC_W]) && (b[FRAC_W-1:0] != '0);
  assign a_snan = a_nan && !a[FRAC_W-1];
  assign b_snan = b_nan && !b[FRAC_W-1];

  assign both_zero = (a_mag == '0) && (b_mag == '0);
  assign equal     = both_zero || (a == b);

  always_comb begin
    if (a[W-1] != b[W-1]) a_less = a[W-1];
    else if (a[W-1])      a_less = a_mag > b_mag;
    else                  a_less = a_mag < b_mag;
  end

  always_comb begin
    if (equal)       ordered = op_max ? (a & b) : (a | b);
    else if (op_max) ordered = a_less ? b : a;
    else             ordered = a_less ? a : b;
  end

  always_comb begin
    nxt = ordered;
    if (a_nan || b_nan) begin
      if (a_nan && b_nan)                            nxt = QNAN;
      else if (nan_mode == 2'b01)                    nxt = QNAN;
      else if (nan_mode != 2'b10 && (a_snan || b_snan)) nxt = QNAN;
      else                                           nxt = a_nan ? b : a;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result  <= '0;
      invalid <= 1'b0;
    end else begin
      result  <= nxt;
      invalid <= a_snan || b_snan;
    end
  end
endmodule

module fp_minmax_checker #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  op_max,
  input logic [1:0]            nan_mode,
  input logic [EXP_W+FRAC_W:0] a,
  input logic [EXP_W+FRAC_W:0] b,
  input logic [EXP_W+FRAC_W:0] result,
  input logic                  invalid
);
  localparam int W = EXP_W + FRAC_W + 1;
  localparam logic [W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic an, bn, as, bs;
  assign an = (&a[W-2:FRAC_W]) && (a[FRAC_W-1:0] != '0);
  assign bn = (&b[W-2:FRAC_W]) && (b[FRAC_W-1:0] != '0);
  assign as = an && !a[FRAC_W-1];
  assign bs = bn && !b[FRAC_W-1];

  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(!rst_n) |-> (result == '0 && !invalid));

  assert_invalid_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (invalid == $past(as || bs)));

  assert_both_nan_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(an && bn)) |-> (result == QNAN));

  assert_propagate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(nan_mode == 2'b01 && (an || bn))) |-> (result == QNAN));

  assert_snan_poison_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(nan_mode[0] == nan_mode[1] && (as || bs))) |-> (result == QNAN));

  assert_suppress_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(nan_mode == 2'b10 && (an != bn)))
      |-> (result == $past(an ? b : a)));

  assert_result_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (result == $past(a) || result == $past(b) || result == QNAN ||
                      result == $past(a & b) || result == $past(a | b)));
endmodule

bind fp_minmax_unit fp_minmax_checker #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_max(op_max), .nan_mode(nan_mode),
  .a(a), .b(b), .result(result), .invalid(invalid)
);

// File: tb/sim_fp_minmax_unit.sv
module sim_fp_minmax_unit;
  localparam int E = 3;
  localparam int F = 2;
  localparam int W = E + F + 1;
  localparam logic [W-1:0] QN = {1'b0, {E{1'b1}}, 1'b1, {(F-1){1'b0}}};

  logic clk = 0;
  logic rst_n = 0;
  logic op_max = 0;
  logic [1:0] nan_mode = 0;
  logic [W-1:0] a = 0, b = 0, result;
  logic invalid;

  logic op32 = 0;
  logic [1:0] mode32 = 0;
  logic [31:0] a32 = 0, b32 = 0, res32;
  logic inv32;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  fp_minmax_unit #(.EXP_W(E), .FRAC_W(F)) u0 (
    .clk(clk), .rst_n(rst_n), .op_max(op_max), .nan_mode(nan_mode),
    .a(a), .b(b), .result(result), .invalid(invalid));

  fp_minmax_unit u1 (
    .clk(clk), .rst_n(rst_n), .op_max(op32), .nan_mode(mode32),
    .a(a32), .b(b32), .result(res32), .invalid(inv32));

  function automatic bit is_nan(logic [W-1:0] x);
    return (x[W-2:F] == {E{1'b1}}) && (x[F-1:0] != 0);
  endfunction

  function automatic bit is_snan(logic [W-1:0] x);
    return is_nan(x) && !x[F-1];
  endfunction

  function automatic int key(logic [W-1:0] x);
    int e, f, m;
    e = int'(x[W-2:F]);
    f = int'(x[F-1:0]);
    if (e == 0) m = f;
    else if (e == (1 << E) - 1) m = 1000000;
    else m = ((1 << F) + f) << (e - 1);
    return x[W-1] ? -m : m;
  endfunction

  function automatic logic [W-1:0] model(logic [W-1:0] x, logic [W-1:0] y, logic op, logic [1:0] md);
    bit xn, yn;
    int kx, ky;
    xn = is_nan(x);
    yn = is_nan(y);
    if (xn && yn) return QN;
    if (md == 2'b01 && (xn || yn)) return QN;
    if (md != 2'b10 && (is_snan(x) || is_snan(y))) return QN;
    if (xn) return y;
    if (yn) return x;
    kx = key(x);
    ky = key(y);
    if (kx == ky) return op ? (x & y) : (x | y);
    if (op) return (kx > ky) ? x : y;
    return (kx < ky) ? x : y;
  endfunction

  function automatic string tag(logic [W-1:0] x, logic [W-1:0] y, logic [1:0] md);
    bit xn, yn;
    xn = is_nan(x);
    yn = is_nan(y);
    if (xn && yn) return "R8";
    if (!xn && !yn) return (key(x) == key(y)) ? "R3" : "R2";
    if (md == 2'b01) return "R6";
    if (md == 2'b10) return "R7";
    if (is_snan(x) || is_snan(y)) return "R5";
    return "R4";
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] r_ab, r_ba, exp;
    logic i_ab, i_ba;
    a = 6'h1F; b = 6'h2A; op_max = 1;
    @(negedge clk); @(negedge clk);
    check(result == 0, "R1 reset result", 32'(result), 0);
    check(invalid == 0, "R1 reset invalid", 32'(invalid), 0);
    rst_n = 1;

    for (int md = 0; md < 4; md++)
      for (int op = 0; op < 2; op++)
        for (int x = 0; x < (1 << W); x++)
          for (int y = x; y < (1 << W); y++) begin
            nan_mode = 2'(md); op_max = op[0];
            a = W'(x); b = W'(y);
            @(posedge clk); @(negedge clk);
            r_ab = result; i_ab = invalid;
            a = W'(y); b = W'(x);
            @(posedge clk); @(negedge clk);
            r_ba = result; i_ba = invalid;
            exp = model(W'(x), W'(y), op[0], 2'(md));
            check(r_ab == exp, tag(W'(x), W'(y), 2'(md)), 32'(r_ab), 32'(exp));
            check(i_ab == (is_snan(W'(x)) || is_snan(W'(y))), "R9", 32'(i_ab),
                  32'(is_snan(W'(x)) || is_snan(W'(y))));
            check(r_ba == r_ab && i_ba == i_ab, "R10", {r_ba, 1'b0, i_ba}, {r_ab, 1'b0, i_ab});
          end

    op32 = 1; mode32 = 2'b00; a32 = 32'h0000_0000; b32 = 32'h8000_0000;
    @(posedge clk); @(negedge clk);
    check(res32 == 32'h0000_0000, "R3 max zeros binary32", res32, 32'h0);
    op32 = 0;
    @(posedge clk); @(negedge clk);
    check(res32 == 32'h8000_0000, "R3 min zeros binary32", res32, 32'h8000_0000);
    a32 = 32'h3F80_0000; b32 = 32'h7F80_0001;
    @(posedge clk); @(negedge clk);
    check(res32 == 32'h7FC0_0000 && inv32, "R11 snan binary32", res32, 32'h7FC0_0000);
    mode32 = 2'b10; op32 = 1; b32 = 32'hFFC1_2345;
    @(posedge clk); @(negedge clk);
    check(res32 == 32'h3F80_0000 && !inv32, "R7 binary32", res32, 32'h3F80_0000);
    a32 = 32'hC000_0000; b32 = 32'hBF80_0000; mode32 = 2'b01;
    @(posedge clk); @(negedge clk);
    check(res32 == 32'hBF80_0000, "R2 negatives binary32", res32, 32'hBF80_0000);
    a32 = 32'hFF80_0000; op32 = 0;
    @(posedge clk); @(negedge clk);
    check(res32 == 32'hFF80_0000, "R2 infinity binary32", res32, 32'hFF80_0000);

    rst_n = 0;
    @(posedge clk); @(negedge clk);
    check(result == 0 && invalid == 0, "R1 re-reset", 32'(result), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule